// File: doc/BRIEF.md
# DMX512 Universe Transmitter

This block sends one complete lighting-control universe on a single serial output line each time it is asked to. A start request captures a channel count. The line is then pulled low for a long break and released high for a short mark. After the mark the block streams asynchronous serial bytes back to back: one low start bit, eight data bits sent least significant bit first, and two high stop bits. Each bit lasts one bit period of the clock divider.

Channel bytes come from an external buffer through a byte-wide read port. The block drives the address, and the buffer returns the byte at that address. Indices below the captured channel count are sent from the buffer in ascending order. Every later position up to the fixed universe length is sent as a zero byte. The bit period and the break and mark lengths are derived from clock-frequency, baud and microsecond parameters; the defaults are 16 MHz, 250000 baud, 88 us and 8 us. The `busy_o` output covers the whole universe, and a single-cycle `done_o` marks its end.

Top module: `dmx_tx`

## Requirements
- R1: Out of reset, and whenever no universe is in progress, `line_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: When `start_i` is sampled high while idle, `line_o` goes low on that clock edge and stays low for exactly BREAK_CYC cycles (1408 at the defaults).
- R3: The break is followed by exactly MARK_CYC cycles of `line_o` high (128 at the defaults), and the first start bit begins directly after them.
- R4: Each byte occupies 11 consecutive bit periods of BIT_CYC cycles (64 at the defaults): a 0 start bit, data bits 0 through 7 in that order, then two 1 stop bits. The next start bit follows the last stop bit with no idle cycle.
- R5: Byte k, for k below the captured channel count, carries `rd_data_i` as sampled on the edge where its start bit begins. At that edge `rd_addr_o` equals k, and it has held k since the start bit of byte k-1 (since the start request for k = 0).
- R6: Byte positions at or above the captured channel count are sent as 0x00.
- R7: Exactly FRAME_BYTES bytes (258) go out per universe. A channel count above FRAME_BYTES is treated as FRAME_BYTES.
- R8: `done_o` is high for exactly the one cycle after the last stop bit of the final byte. `busy_o` falls on that same edge, and it is high from the start edge until then.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the line.
- R10: `num_ch_i` is captured with the start request. Changes to it while busy have no effect on the universe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one universe |
| num_ch_i | input | AW (9) | Number of channel bytes taken from the buffer |
| rd_addr_o | output | AW (9) | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o` |
| line_o | output | 1 | Serial output line, idle high |
| busy_o | output | 1 | Universe in progress |
| done_o | output | 1 | One-cycle end-of-universe pulse |

## Verification
Every result of this block falls on a fixed cycle once the start edge is known. The break covers the first BREAK_CYC cycles after that edge and the mark covers the next MARK_CYC. Bit b of byte k begins BREAK_CYC + MARK_CYC + (11k + b)·BIT_CYC cycles after the start edge, and `done_o` is due on the cycle right after the final stop bit. The bench drives `start_i` after a falling edge and then samples every falling edge. For each sample it computes the expected line level from this schedule, so it checks the level for the full length of every break, mark and bit, and it checks `done_o` and `busy_o` on their exact cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BREAK,
    PH_MARK,
    PH_DATA
  } dmx_phase_e;
endpackage

// File: rtl/dmx_timer.sv
module dmx_timer #(
  parameter int TW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dmx_shifter.sv
module dmx_shifter #(
  parameter int DW    = 8,
  parameter int STOPB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] byte_i,
  output logic          bit_o
);
  localparam int FW = 1 + DW + STOPB;
  logic [FW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (load_i)   sh_q <= {{STOPB{1'b1}}, byte_i, 1'b0};
    else if (shift_i)  sh_q <= {1'b1, sh_q[FW-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/dmx_tx.sv
module dmx_tx #(
  parameter int CLK_HZ      = 16_000_000,
  parameter int BAUD        = 250_000,
  parameter int BREAK_US    = 88,
  parameter int MARK_US     = 8,
  parameter int FRAME_BYTES = 258,
  parameter int DW          = 8,
  parameter int STOPB       = 2,
  parameter int AW          = $clog2(FRAME_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] num_ch_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          line_o,
  output logic          busy_o,
  output logic          done_o
);
  import dmx_pkg::*;

  localparam int BIT_CYC   = CLK_HZ / BAUD;
  localparam int BREAK_CYC = (CLK_HZ / 1_000_000) * BREAK_US;
  localparam int MARK_CYC  = (CLK_HZ / 1_000_000) * MARK_US;
  localparam int FW        = 1 + DW + STOPB;
  localparam int MAXC      = (BREAK_CYC > MARK_CYC) ?
                             ((BREAK_CYC > BIT_CYC) ? BREAK_CYC : BIT_CYC) :
                             ((MARK_CYC > BIT_CYC) ? MARK_CYC : BIT_CYC);
  localparam int TW        = $clog2(MAXC + 1);
  localparam int BW        = $clog2(FW);

  dmx_phase_e    phase_q, phase_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] nch_q, nch_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          done_q, done_d;

  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sh_ld, sh_shift, sh_bit;
  logic [DW-1:0] next_byte;

  // positions past the captured count are padding
  assign next_byte = (idx_q < nch_q) ? rd_data_i : '0;

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    nch_d    = nch_q;
    bit_d    = bit_q;
    done_d   = 1'b0;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    sh_ld    = 1'b0;
    sh_shift = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_BREAK;
        idx_d   = '0;
        nch_d   = (num_ch_i > AW'(FRAME_BYTES)) ? AW'(FRAME_BYTES) : num_ch_i;
        tmr_ld  = 1'b1;
        tmr_val = TW'(BREAK_CYC - 1);
      end
      PH_BREAK: if (tmr_zero) begin
        phase_d = PH_MARK;
        tmr_ld  = 1'b1;
        tmr_val = TW'(MARK_CYC - 1);
      end
      PH_MARK: if (tmr_zero) begin
        phase_d = PH_DATA;
        tmr_ld  = 1'b1;
        tmr_val = TW'(BIT_CYC - 1);
        sh_ld   = 1'b1;
        bit_d   = '0;
        idx_d   = idx_q + 1'b1;
      end
      PH_DATA: if (tmr_zero) begin
        if (bit_q == BW'(FW - 1)) begin
          if (idx_q == AW'(FRAME_BYTES)) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            tmr_ld  = 1'b1;
            tmr_val = TW'(BIT_CYC - 1);
            sh_ld   = 1'b1;
            bit_d   = '0;
            idx_d   = idx_q + 1'b1;
          end
        end else begin
          tmr_ld   = 1'b1;
          tmr_val  = TW'(BIT_CYC - 1);
          sh_shift = 1'b1;
          bit_d    = bit_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      nch_q   <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      nch_q   <= nch_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  dmx_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  dmx_shifter #(.DW(DW), .STOPB(STOPB)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_ld),
    .shift_i (sh_shift),
    .byte_i  (next_byte),
    .bit_o   (sh_bit)
  );

  assign rd_addr_o = idx_q;
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign line_o    = (phase_q == PH_BREAK) ? 1'b0 :
                     (phase_q == PH_DATA)  ? sh_bit : 1'b1;
endmodule

// File: rtl/dmx_tx_sva.sv
module dmx_tx_sva #(
  parameter int AW          = 9,
  parameter int FRAME_BYTES = 258
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          line_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> line_o);

  a_r2_break_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_busy_falls_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  a_r7_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_o <= AW'(FRAME_BYTES));
endmodule

bind dmx_tx dmx_tx_sva #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rd_addr_o (rd_addr_o),
  .line_o    (line_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/dmx_tx_tb.sv
module dmx_tx_tb;
  localparam int CLK_HZ = 2_000_000;
  localparam int BAUD   = 250_000;
  localparam int BIT    = CLK_HZ / BAUD;
  localparam int BRK    = (CLK_HZ / 1_000_000) * 88;
  localparam int MRK    = (CLK_HZ / 1_000_000) * 8;
  localparam int FB     = 258;
  localparam int FWB    = 11;
  localparam int AW     = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] num_ch_i = '0;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i;
  logic          line_o, busy_o, done_o;
  logic [7:0]    mem [0:511];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  assign rd_data_i = mem[rd_addr_o];

  dmx_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FRAME_BYTES(FB)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .num_ch_i  (num_ch_i),
    .rd_addr_o (rd_addr_o),
    .rd_data_i (rd_data_i),
    .line_o    (line_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * seed) + 8'h5a + (a >> 3));
  endtask

  function automatic string seg_req(input int seg, input int eff);
    if (seg == 0) return "R2 break";
    if (seg == 1) return "R3 mark";
    if (seg - 2 < eff) return $sformatf("R4/R5 byte %0d", seg - 2);
    return $sformatf("R4/R6 pad byte %0d", seg - 2);
  endfunction

  // one universe; poke=1 pulses start and alters the count mid-stream (R9, R10)
  task automatic run_universe(input int nch, input bit poke);
    int eff, D, cur_seg, seg, exp_l, j, k, b, busy_bad, done_bad;
    bit bad;
    int bad_act, bad_exp;
    logic [7:0] byt;
    eff = (nch > FB) ? FB : nch;
    D = BRK + MRK + FB * FWB * BIT + 1;
    cur_seg = 0; bad = 0; bad_act = 0; bad_exp = 0; busy_bad = 0; done_bad = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    num_ch_i = AW'(nch);
    for (int i = 1; i < D; i++) begin
      @(negedge clk_i);
      if (i == 1) start_i = 1'b0;
      if (poke && i == BRK + MRK + 500) begin start_i = 1'b1; num_ch_i = AW'(3); end
      if (poke && i == BRK + MRK + 501) start_i = 1'b0;
      if (i <= BRK) begin seg = 0; exp_l = 0; end
      else if (i <= BRK + MRK) begin seg = 1; exp_l = 1; end
      else begin
        j = i - BRK - MRK - 1;
        k = j / (FWB * BIT);
        b = (j / BIT) % FWB;
        byt = (k < eff) ? mem[k] : 8'h00;
        seg = 2 + k;
        if (b == 0) exp_l = 0;
        else if (b <= 8) exp_l = int'(byt[b-1]);
        else exp_l = 1;
      end
      if (seg != cur_seg) begin
        check(!bad, seg_req(cur_seg, eff), bad_act, bad_exp);
        cur_seg = seg; bad = 0;
      end
      if (line_o !== 1'(exp_l) && !bad) begin
        bad = 1; bad_act = int'(line_o); bad_exp = exp_l;
      end
      if (busy_o !== 1'b1) busy_bad++;
      if (done_o !== 1'b0) done_bad++;
    end
    check(!bad, seg_req(cur_seg, eff), bad_act, bad_exp);
    check(busy_bad == 0, "R8 busy held through universe", busy_bad, 0);
    check(done_bad == 0, "R8 no early done", done_bad, 0);
    @(negedge clk_i);
    check(done_o === 1'b1, "R7/R8 done after byte 258", int'(done_o), 1);
    check(busy_o === 1'b0, "R8 busy falls with done", int'(busy_o), 0);
    check(line_o === 1'b1, "R1 line idle after universe", int'(line_o), 1);
    @(negedge clk_i);
    check(done_o === 1'b0, "R8 done lasts one cycle", int'(done_o), 0);
    check(line_o === 1'b1 && busy_o === 1'b0, "R1 idle state", int'(line_o), 1);
  endtask

  task automatic test_reset();
    check(line_o === 1'b1, "R1 reset line", int'(line_o), 1);
    check(busy_o === 1'b0, "R1 reset busy", int'(busy_o), 0);
    check(done_o === 1'b0, "R1 reset done", int'(done_o), 0);
  endtask

  task automatic test_short();   fill_mem(37); run_universe(5, 1'b0);   endtask
  task automatic test_empty();   fill_mem(11); run_universe(0, 1'b0);   endtask
  task automatic test_clamp();   fill_mem(73); run_universe(300, 1'b0); endtask
  task automatic test_full_poke(); fill_mem(29); run_universe(258, 1'b1); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_short();
    test_empty();
    test_clamp();
    test_full_poke();
    repeat (20) @(negedge clk_i);
    check(line_o === 1'b1 && done_o === 1'b0, "R1 quiet after runs", int'(line_o), 1);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule